// File: doc/BRIEF.md
# Configurable Framing Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single output line. A character of up to nine bits is handed over through a valid/ready handshake together with its framing settings: character length, bit order, the kind of bit that follows the data (parity, a forced level, an address flag, or nothing) and the length of the stop period. The settings are captured with the character, so each frame can be framed differently.

Timing comes from a one-cycle enable pulse supplied at sixteen times the bit rate. Every bit occupies sixteen such pulses, which lets the stop period be one, one and a half or two bits long. A busy output marks the whole frame from the first edge of the start bit to the end of the last stop tick; a new character is taken only while the line is idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: `in_ready` equals the inverse of `busy`; a character offered while busy is ignored and neither alters the frame in progress nor starts another one.
- R3: A frame begins with a start bit at level 0 lasting 16 ticks, starting in the cycle after the handshake completes, when `busy` also rises.
- R4: With `cfg_nine` = 0 the number of data bits is 5 + `cfg_len` (`cfg_len` 0..3 gives 5..8); higher input bits are not sent.
- R5: With `cfg_nine` = 1 exactly nine data bits are sent regardless of `cfg_len`.
- R6: `cfg_msb_first` = 0 sends bit 0 first; = 1 sends the highest sent bit first.
- R7: `cfg_parity` = 0 appends an even-parity bit and = 1 an odd-parity bit, both computed only over the data bits actually sent.
- R8: `cfg_parity` = 2 appends a constant 0 bit and = 3 a constant 1 bit.
- R9: `cfg_parity` = 4, 6 or 7 appends no bit after the data.
- R10: `cfg_parity` = 5 appends the `in_addr` flag (1 for an address character, 0 for data).
- R11: The stop period is at level 1 and lasts 16 ticks for `cfg_stop` = 0, 24 ticks for 1, 32 ticks for 2, and 16 ticks for the reserved value 3.
- R12: `busy` stays 1 from the start bit to the last stop tick and falls in the cycle after that tick.
- R13: Every bit advances only on cycles where `tick` is 1; between ticks `txd` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character accepted when high with `in_valid` |
| in_data | input | 9 | Character bits, bit 0 lowest |
| in_addr | input | 1 | Address flag used in multidrop framing |
| cfg_len | input | 2 | Character length select (5..8 bits) |
| cfg_nine | input | 1 | Force nine data bits |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_parity | input | 3 | Trailing bit select |
| cfg_stop | input | 2 | Stop length select |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The hardest situation to reach is a character offered in the middle of a frame, since the handshake normally waits for the line to go idle. The bench holds `in_valid` high with different data and settings for dozens of cycles right after a frame starts, then compares the whole recorded tick-by-tick waveform against the original character and watches that no second frame follows. Odd tick spacing and the half-bit stop length are reached by changing the tick divider and the stop select per scenario, and parity over short characters uses data with the unsent upper bits set so that a parity taken over all nine bits would differ.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    localparam int MAX_DATA = 9;
    localparam int SER_W    = MAX_DATA + 1;
    localparam int NB_W     = $clog2(SER_W + 1);

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_RSVD     = 2'd3
    } stop_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_START,
        SQ_DATA,
        SQ_STOP
    } seq_state_e;

    typedef struct packed {
        logic [SER_W-1:0] bits;   // bit 0 goes out first after the start bit
        logic [NB_W-1:0]  nbits;  // data plus trailing bit count
        stop_mode_e       stop;
    } frame_t;

    function automatic int data_len(input logic nine, input logic [1:0] len);
        return nine ? MAX_DATA : 5 + int'(len);
    endfunction

    function automatic int stop_ticks(input stop_mode_e m, input int tpb);
        case (m)
            STOP_ONE_HALF: return tpb + tpb / 2;
            STOP_TWO:      return 2 * tpb;
            default:       return tpb;
        endcase
    endfunction

endpackage

// File: rtl/uart_txf_framer.sv
module uart_txf_framer
    import uart_txf_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  logic                addr_flag,
    input  logic [1:0]          len,
    input  logic                nine,
    input  logic                msb_first,
    input  logic [2:0]          par_sel,
    input  logic [1:0]          stop_sel,
    output frame_t              frame
);

    logic [MAX_DATA-1:0] keep;
    logic                odd_ones;
    logic                has_trail;
    logic                trail_bit;
    int                  nd;

    always_comb begin
        nd = data_len(nine, len);
        for (int i = 0; i < MAX_DATA; i++) begin
            keep[i] = (i < nd);
        end
        odd_ones = ^(data & keep);

        has_trail = 1'b1;
        trail_bit = 1'b0;
        case (par_sel)
            3'd0: trail_bit = odd_ones;
            3'd1: trail_bit = ~odd_ones;
            3'd2: trail_bit = 1'b0;
            3'd3: trail_bit = 1'b1;
            3'd5: trail_bit = addr_flag;
            default: has_trail = 1'b0;
        endcase

        frame.bits = '0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < nd) begin
                frame.bits[i] = msb_first ? data[nd - 1 - i] : data[i];
            end
        end
        if (has_trail) begin
            frame.bits[nd] = trail_bit;
        end
        frame.nbits = NB_W'(nd + int'(has_trail));
        frame.stop  = stop_mode_e'(stop_sel);
    end

    // R4
    always_comb begin
        framer_len_chk: assert (frame.nbits >= NB_W'(5) && frame.nbits <= NB_W'(SER_W))
            else $error("frame length out of range");
    end

endmodule

// File: rtl/uart_txf_seq.sv
module uart_txf_seq
    import uart_txf_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame_in,
    output logic   txd,
    output logic   busy
);

    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

    seq_state_e       state;
    logic [SER_W-1:0] shreg;
    logic [NB_W-1:0]  left;
    stop_mode_e       stop_m;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        if (state == SQ_STOP) begin
            last_cnt = CNT_W'(stop_ticks(stop_m, TICKS_PER_BIT) - 1);
        end else begin
            last_cnt = CNT_W'(TICKS_PER_BIT - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            shreg  <= '0;
            left   <= '0;
            stop_m <= STOP_ONE;
            cnt    <= '0;
        end else if (state == SQ_IDLE) begin
            if (load) begin
                state  <= SQ_START;
                shreg  <= frame_in.bits;
                left   <= frame_in.nbits;
                stop_m <= frame_in.stop;
                cnt    <= '0;
            end
        end else if (tick) begin
            if (cnt == last_cnt) begin
                cnt <= '0;
                case (state)
                    SQ_START: state <= SQ_DATA;
                    SQ_DATA: begin
                        shreg <= shreg >> 1;
                        left  <= left - 1'b1;
                        if (left == NB_W'(1)) begin
                            state <= SQ_STOP;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign busy = (state != SQ_IDLE);
    assign txd  = (state == SQ_DATA) ? shreg[0] : (state != SQ_START);

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R13
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !load) |=> $stable(txd));

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(2 * TICKS_PER_BIT - 1));

    // R12
    end_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(state) == SQ_STOP && $past(tick)));

    // R2
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(shreg));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_txf_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [8:0] in_data,
    input  logic       in_addr,
    input  logic [1:0] cfg_len,
    input  logic       cfg_nine,
    input  logic       cfg_msb_first,
    input  logic [2:0] cfg_parity,
    input  logic [1:0] cfg_stop,
    output logic       txd,
    output logic       busy
);

    frame_t next_frame;
    logic   load;

    uart_txf_framer u_framer (
        .data      (in_data),
        .addr_flag (in_addr),
        .len       (cfg_len),
        .nine      (cfg_nine),
        .msb_first (cfg_msb_first),
        .par_sel   (cfg_parity),
        .stop_sel  (cfg_stop),
        .frame     (next_frame)
    );

    assign in_ready = ~busy;
    assign load     = in_valid & in_ready;

    uart_txf_seq #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .frame_in (next_frame),
        .txd      (txd),
        .busy     (busy)
    );

endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic       in_addr = 1'b0;
    logic [1:0] cfg_len = '0;
    logic       cfg_nine = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [2:0] cfg_parity = 3'd4;
    logic [1:0] cfg_stop = '0;
    logic       txd;
    logic       busy;

    int tests = 0;
    int fails = 0;
    int tdiv  = 1;
    int tcnt  = 0;

    int exp_bit [0:15];
    int exp_n;
    int exp_stop;
    int samp [0:255];
    int nsamp;

    always #2.5 clk = ~clk;

    uart_frame_tx uut (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .in_addr       (in_addr),
        .cfg_len       (cfg_len),
        .cfg_nine      (cfg_nine),
        .cfg_msb_first (cfg_msb_first),
        .cfg_parity    (cfg_parity),
        .cfg_stop      (cfg_stop),
        .txd           (txd),
        .busy          (busy)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (tcnt >= tdiv - 1) begin
                tick = 1'b1;
                tcnt = 0;
            end else begin
                tick = 1'b0;
                tcnt++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_exp(input logic [8:0] d, input logic a, input logic [1:0] len,
                             input logic nine, input logic msb, input logic [2:0] par,
                             input logic [1:0] stp);
        int nd;
        int x;
        int has;
        int pb;
        nd = nine ? 9 : 5 + int'(len);
        exp_bit[0] = 0;
        x = 0;
        for (int i = 0; i < nd; i++) begin
            x = x ^ int'(d[i]);
            exp_bit[1 + i] = msb ? int'(d[nd - 1 - i]) : int'(d[i]);
        end
        has = 1;
        pb = 0;
        case (par)
            3'd0: pb = x;
            3'd1: pb = 1 - x;
            3'd2: pb = 0;
            3'd3: pb = 1;
            3'd5: pb = int'(a);
            default: has = 0;
        endcase
        if (has == 1) exp_bit[1 + nd] = pb;
        exp_n = 1 + nd + has;
        case (stp)
            2'd1: exp_stop = 24;
            2'd2: exp_stop = 32;
            default: exp_stop = 16;
        endcase
    endtask

    task automatic run_frame(input string req, input logic [8:0] d, input logic a,
                             input logic [1:0] len, input logic nine, input logic msb,
                             input logic [2:0] par, input logic [1:0] stp,
                             input int div, input bit poke);
        int bad_start;
        int bad_body;
        int bad_stop;
        int iter;
        int bad_ready;
        build_exp(d, a, len, nine, msb, par, stp);
        tdiv = div;
        @(negedge clk);
        in_data = d; in_addr = a; cfg_len = len; cfg_nine = nine;
        cfg_msb_first = msb; cfg_parity = par; cfg_stop = stp;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        // R12 busy rises with the start bit, R3 line goes low
        check("R12 busy after accept", int'(busy), 1);
        check("R3 start level", int'(txd), 0);
        if (poke) begin
            in_data = ~d; in_addr = ~a; cfg_parity = 3'd3; cfg_stop = 2'd2;
            cfg_msb_first = ~msb;
        end else begin
            in_valid = 1'b0;
        end
        nsamp = 0;
        iter = 0;
        bad_ready = 0;
        while (busy && nsamp < 256) begin
            if (tick) begin
                samp[nsamp] = int'(txd);
                nsamp++;
            end
            if (poke && in_ready) bad_ready++;
            iter++;
            if (poke && iter == 40) in_valid = 1'b0;
            @(negedge clk);
            #1;
        end
        in_valid = 1'b0;
        bad_start = 0; bad_body = 0; bad_stop = 0;
        for (int k = 0; k < nsamp; k++) begin
            if (k < 16) begin
                if (samp[k] != 0) bad_start++;
            end else if (k < 16 * exp_n) begin
                if (samp[k] != exp_bit[k / 16]) bad_body++;
            end else begin
                if (samp[k] != 1) bad_stop++;
            end
        end
        check("R3 start bit ticks", bad_start, 0);
        check({req, " frame bits"}, bad_body, 0);
        check("R11 stop level", bad_stop, 0);
        check({"R11 R12 frame tick count (", req, ")"}, nsamp, 16 * exp_n + exp_stop);
        if (poke) check("R2 in_ready low while busy", bad_ready, 0);
        repeat (20) @(negedge clk);
        #1;
        // R1 back to idle, R2 no second frame from ignored offer
        check({"R1 R2 idle after frame (", req, ")"}, int'({busy, txd, in_ready}), 3);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset txd", int'(txd), 1);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset in_ready", int'(in_ready), 1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        test_reset();
        repeat (4) @(negedge clk);
        // R4 R9 eight bits, no trailing bit
        run_frame("R4 R9 8-bit", 9'h0A5, 1'b0, 2'd3, 1'b0, 1'b0, 3'd4, 2'd0, 1, 1'b0);
        // R4 five bits, upper bits dropped
        run_frame("R4 5-bit", 9'h1F3, 1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 2'd0, 1, 1'b0);
        run_frame("R4 6-bit", 9'h12D, 1'b0, 2'd1, 1'b0, 1'b0, 3'd6, 2'd0, 1, 1'b0);
        // R5 nine bits override length
        run_frame("R5 9-bit", 9'h1A5, 1'b0, 2'd0, 1'b1, 1'b0, 3'd7, 2'd0, 1, 1'b0);
        // R6 order
        run_frame("R6 msb first", 9'h0B1, 1'b0, 2'd3, 1'b0, 1'b1, 3'd4, 2'd0, 1, 1'b0);
        run_frame("R6 msb first 7-bit", 9'h043, 1'b0, 2'd2, 1'b0, 1'b1, 3'd4, 2'd0, 1, 1'b0);
        // R7 parity over sent bits only (upper bits set)
        run_frame("R7 even", 9'h0E1, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1, 1'b0);
        run_frame("R7 odd", 9'h0E1, 1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 2'd0, 1, 1'b0);
        run_frame("R7 even 9-bit", 9'h1C3, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 2'd0, 1, 1'b0);
        // R8 forced levels
        run_frame("R8 space", 9'h0FF, 1'b0, 2'd3, 1'b0, 1'b0, 3'd2, 2'd0, 1, 1'b0);
        run_frame("R8 mark", 9'h000, 1'b0, 2'd3, 1'b0, 1'b0, 3'd3, 2'd0, 1, 1'b0);
        // R10 multidrop flag
        run_frame("R10 address", 9'h055, 1'b1, 2'd3, 1'b0, 1'b0, 3'd5, 2'd0, 1, 1'b0);
        run_frame("R10 data", 9'h055, 1'b0, 2'd3, 1'b0, 1'b0, 3'd5, 2'd0, 1, 1'b0);
        // R11 stop lengths
        run_frame("R11 1.5 stop", 9'h03C, 1'b0, 2'd3, 1'b0, 1'b0, 3'd4, 2'd1, 1, 1'b0);
        run_frame("R11 2 stop", 9'h03C, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 2'd2, 1, 1'b0);
        run_frame("R11 reserved stop", 9'h03C, 1'b0, 2'd3, 1'b0, 1'b0, 3'd4, 2'd3, 1, 1'b0);
        // R13 sparse ticks
        run_frame("R13 tick every 3", 9'h169, 1'b0, 2'd0, 1'b1, 1'b1, 3'd1, 2'd1, 3, 1'b0);
        // R2 offers during a frame are ignored
        run_frame("R2 offer while busy", 9'h0A3, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 2'd0, 1, 1'b1);
        run_frame("R2 offer while busy slow", 9'h11E, 1'b1, 2'd0, 1'b1, 1'b0, 3'd5, 2'd2, 2, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule